// File: doc/BRIEF.md
# ITU-656 Receive Timing Decoder

This block sits on the receive side of a digital video port. It takes the word stream of a BT.656-style interface, one word per enabled clock, 8 or 10 bits wide. Inside that stream it finds the four-word timing codes. From the status word of each code it takes the field (F), vertical-blanking (V) and horizontal-blanking (H) flags. Before the flags are used, the parity bits of the status word repair any single-bit error.

The decoder forwards only the samples that the selected capture mode admits. The three capture modes are active picture only, the active part of vertical-blanking lines only, and the whole field including horizontal blanking. A fourth setting forwards nothing. Each forwarded sample comes with a valid strobe, the flags that were in force for it, a line-start marker and a field-start marker. The timing-code words themselves are never forwarded.

A three-word delay line makes this possible. A preamble is recognised only once its status word has arrived, and by then its leading words have not yet left the delay line, so they can still be removed from the output.

Top module: `vid656_rx`

## Requirements
- R1: A timing code is one all-ones word, then two all-zeros words, then a status word. All four words are consumed and never appear on `out_data`. Every other sample that the mode admits is forwarded once, in arrival order.
- R2: The status byte is the top 8 bits of the word. Its layout is bit6 = F, bit5 = V, bit4 = H, and bits 3:0 are four parity bits: bit3 = V^H, bit2 = F^H, bit1 = F^V, bit0 = F^V^H.
- R3: A status word with exactly one flipped bit among bits 6:0 is decoded to the original F/V/H. In this case `xy_fixed` pulses for one cycle after the clock edge that sampled that word.
- R4: A status word with two flipped bits among bits 6:0 raises `xy_bad` for one cycle and never `xy_fixed`. The F/V/H flags keep their previous values, and the code arms neither a line start nor a field start.
- R5: After reset, no sample is forwarded until the first status word that is valid or correctable.
- R6: Capture mode 0 (`cap_mode`=2'd0) forwards only samples with V=0 and H=0.
- R7: Capture mode 1 (`cap_mode`=2'd1) forwards only samples with V=1 and H=0.
- R8: Capture mode 2 (`cap_mode`=2'd2) forwards every sample that is not part of a timing code, horizontal blanking included.
- R9: Capture mode 3 (`cap_mode`=2'd3) forwards nothing.
- R10: A word sampled at one enabled edge appears on `out_data` at the third enabled edge after it, with `out_valid` high for that one clock. Clocks with `din_en` low neither advance the stream nor raise `out_valid`.
- R11: `out_line_start` is high on the first forwarded sample after each code that decodes with H=1.
- R12: `out_field_start` is high on the first forwarded sample after a decoded code whose F differs from the held F. The held F is 0 after reset.
- R13: `out_field`, `out_vblank` and `out_hblank` carry the F, V and H values that were in force for the forwarded sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_en | input | 1 | Word on `din` is taken at this edge |
| din | input | DATA_W | Received video word |
| cap_mode | input | 2 | Capture mode: 0 active, 1 vertical blanking, 2 whole field, 3 none |
| out_data | output | DATA_W | Forwarded sample |
| out_valid | output | 1 | `out_data` holds a new sample |
| out_line_start | output | 1 | First forwarded sample of a line |
| out_field_start | output | 1 | First forwarded sample after an F change |
| out_field | output | 1 | F in force for the sample |
| out_vblank | output | 1 | V in force for the sample |
| out_hblank | output | 1 | H in force for the sample |
| xy_fixed | output | 1 | Last status word had a corrected single-bit error |
| xy_bad | output | 1 | Last status word was uncorrectable |

## Verification
The checker watches every cycle for the following:
- `xy_fixed` and `xy_bad` never rise together, and a rejected status word leaves the held flags unchanged.
- Nothing is forwarded before the first sync.
- In the active and vertical-blanking modes, every forwarded sample carries the flag values those modes require.
- `out_valid` follows only an enabled edge.
- The start markers appear only on valid samples.

Other behaviours need the bench's scenarios and its independent model of the stream:
- the parity correction, checked against every single and double error on every flag combination;
- the order and completeness of the forwarded samples;
- the removal of the timing-code words;
- the exact placement of the line-start and field-start markers;
- the three-enabled-edge latency across idle gaps.

// File: rtl/vid656_pkg.sv
package vid656_pkg;

  typedef enum logic [1:0] {
    CAP_ACTIVE = 2'd0,
    CAP_VBLANK = 2'd1,
    CAP_FIELD  = 2'd2,
    CAP_NONE   = 2'd3
  } cap_mode_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } fvh_t;

  // Parity nibble expected for a given flag set (R2)
  function automatic logic [3:0] prot_bits(fvh_t s);
    return {s.v ^ s.h, s.f ^ s.h, s.f ^ s.v, s.f ^ s.v ^ s.h};
  endfunction

  // Syndrome lookup: {correctable, flip F, flip V, flip H}
  function automatic logic [3:0] syn_fix(logic [3:0] syn);
    case (syn)
      4'b0000, 4'b1000, 4'b0100,
      4'b0010, 4'b0001: return 4'b1000;
      4'b0111:          return 4'b1100;
      4'b1011:          return 4'b1010;
      4'b1101:          return 4'b1001;
      default:          return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/vid656_trs_detect.sv
module vid656_trs_detect #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] cand,
  output logic              match,
  output logic [6:0]        xy_bits
);
  localparam int DEPTH = 3;
  localparam logic [DATA_W-1:0] ALL_ONES  = '1;
  localparam logic [DATA_W-1:0] ALL_ZEROS = '0;

  logic [DATA_W-1:0] tap_q [DEPTH];
  logic [DATA_W-1:0] tap_n [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) tap_n[i] = tap_q[i];
    if (en) begin
      tap_n[0] = din;
      for (int i = 1; i < DEPTH; i++) tap_n[i] = tap_q[i-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q[g] <= '0;
        else        tap_q[g] <= tap_n[g];
      end
    end
  endgenerate

  // Oldest word is the forwarding candidate; status word is the live input
  assign cand    = tap_q[DEPTH-1];
  assign match   = en && (tap_q[2] == ALL_ONES) && (tap_q[1] == ALL_ZEROS)
                   && (tap_q[0] == ALL_ZEROS);
  assign xy_bits = din[DATA_W-2 -: 7];

endmodule

// File: rtl/vid656_xy_decode.sv
module vid656_xy_decode
  import vid656_pkg::*;
(
  input  logic [6:0] xy_bits,
  output fvh_t       fvh,
  output logic       ok,
  output logic       fixed
);
  fvh_t       rx;
  logic [3:0] syn;
  logic [3:0] fix;

  always_comb begin
    rx    = fvh_t'(xy_bits[6:4]);
    syn   = prot_bits(rx) ^ xy_bits[3:0];
    fix   = syn_fix(syn);
    fvh   = rx ^ fvh_t'(fix[2:0]);
    ok    = fix[3];
    fixed = fix[3] && (syn != 4'b0000);
  end

endmodule

// File: rtl/vid656_timing_state.sv
module vid656_timing_state
  import vid656_pkg::*;
#(
  parameter int KILL_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic match,
  input  fvh_t dec_fvh,
  input  logic dec_ok,
  input  logic dec_fixed,
  input  logic fwd,
  output fvh_t fvh_q,
  output logic sync_ok,
  output logic kill,
  output logic line_pend,
  output logic field_pend,
  output logic fixed_q,
  output logic bad_q
);
  localparam int KW = $clog2(KILL_LEN + 1);

  logic [KW-1:0] kcnt_q, kcnt_n;
  fvh_t          fvh_n;
  logic          sync_n, lp_n, fp_n, fixed_n, bad_n, take;

  always_comb begin
    take    = en && match && dec_ok;
    kcnt_n  = kcnt_q;
    if (en) begin
      if (match)               kcnt_n = KW'(KILL_LEN);
      else if (kcnt_q != '0)   kcnt_n = kcnt_q - 1'b1;
    end
    fvh_n   = take ? dec_fvh : fvh_q;
    sync_n  = sync_ok || take;
    lp_n    = line_pend;
    if (take && dec_fvh.h)            lp_n = 1'b1;
    else if (fwd)                     lp_n = 1'b0;
    fp_n    = field_pend;
    if (take && (dec_fvh.f != fvh_q.f)) fp_n = 1'b1;
    else if (fwd)                       fp_n = 1'b0;
    fixed_n = en && match && dec_fixed;
    bad_n   = en && match && !dec_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kcnt_q     <= '0;
      fvh_q      <= '0;
      sync_ok    <= 1'b0;
      line_pend  <= 1'b0;
      field_pend <= 1'b0;
      fixed_q    <= 1'b0;
      bad_q      <= 1'b0;
    end else begin
      kcnt_q     <= kcnt_n;
      fvh_q      <= fvh_n;
      sync_ok    <= sync_n;
      line_pend  <= lp_n;
      field_pend <= fp_n;
      fixed_q    <= fixed_n;
      bad_q      <= bad_n;
    end
  end

  assign kill = (kcnt_q != '0);

endmodule

// File: rtl/vid656_out_gate.sv
module vid656_out_gate
  import vid656_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              match,
  input  logic              kill,
  input  logic              sync_ok,
  input  cap_mode_e         mode,
  input  fvh_t              fvh_q,
  input  logic [DATA_W-1:0] cand,
  input  logic              line_pend,
  input  logic              field_pend,
  output logic              fwd,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q,
  output logic              ls_q,
  output logic              fs_q,
  output fvh_t              flags_q
);
  logic              admit;
  logic [DATA_W-1:0] data_n;
  fvh_t              flags_n;

  always_comb begin
    case (mode)
      CAP_ACTIVE: admit = !fvh_q.v && !fvh_q.h;
      CAP_VBLANK: admit =  fvh_q.v && !fvh_q.h;
      CAP_FIELD:  admit = 1'b1;
      default:    admit = 1'b0;
    endcase
    fwd     = en && sync_ok && !kill && !match && admit;
    data_n  = fwd ? cand  : data_q;
    flags_n = fwd ? fvh_q : flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ls_q    <= 1'b0;
      fs_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      data_q  <= data_n;
      valid_q <= fwd;
      ls_q    <= fwd && line_pend;
      fs_q    <= fwd && field_pend;
      flags_q <= flags_n;
    end
  end

endmodule

// File: rtl/vid656_rx.sv
module vid656_rx
  import vid656_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din_en,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        cap_mode,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_line_start,
  output logic              out_field_start,
  output logic              out_field,
  output logic              out_vblank,
  output logic              out_hblank,
  output logic              xy_fixed,
  output logic              xy_bad
);
  localparam int KILL_LEN = 3;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rst_pipe[SYNC_STAGES-1];

  logic [DATA_W-1:0] cand;
  logic              match, dec_ok, dec_fixed, fwd;
  logic              sync_ok, kill, line_pend, field_pend;
  logic [6:0]        xy_bits;
  fvh_t              dec_fvh, fvh_q, flags_q;

  vid656_trs_detect #(.DATA_W(DATA_W)) u_det (
    .clk(clk), .rst_n(rst_i_n), .en(din_en), .din(din),
    .cand(cand), .match(match), .xy_bits(xy_bits)
  );

  vid656_xy_decode u_dec (
    .xy_bits(xy_bits), .fvh(dec_fvh), .ok(dec_ok), .fixed(dec_fixed)
  );

  vid656_timing_state #(.KILL_LEN(KILL_LEN)) u_st (
    .clk(clk), .rst_n(rst_i_n), .en(din_en), .match(match),
    .dec_fvh(dec_fvh), .dec_ok(dec_ok), .dec_fixed(dec_fixed), .fwd(fwd),
    .fvh_q(fvh_q), .sync_ok(sync_ok), .kill(kill),
    .line_pend(line_pend), .field_pend(field_pend),
    .fixed_q(xy_fixed), .bad_q(xy_bad)
  );

  vid656_out_gate #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_i_n), .en(din_en), .match(match), .kill(kill),
    .sync_ok(sync_ok), .mode(cap_mode_e'(cap_mode)), .fvh_q(fvh_q),
    .cand(cand), .line_pend(line_pend), .field_pend(field_pend),
    .fwd(fwd), .data_q(out_data), .valid_q(out_valid),
    .ls_q(out_line_start), .fs_q(out_field_start), .flags_q(flags_q)
  );

  assign out_field  = flags_q.f;
  assign out_vblank = flags_q.v;
  assign out_hblank = flags_q.h;

endmodule

// File: rtl/vid656_rx_chk.sv
module vid656_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       din_en,
  input logic [1:0] cap_mode,
  input logic       out_valid,
  input logic       out_line_start,
  input logic       out_field_start,
  input logic       out_vblank,
  input logic       out_hblank,
  input logic       xy_fixed,
  input logic       xy_bad,
  input logic [2:0] fvh_q,
  input logic       sync_ok
);
  p_fix_bad_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(xy_fixed && xy_bad));

  p_bad_keeps_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xy_bad |-> $stable(fvh_q));

  p_no_fwd_unsynced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ok |-> !out_valid);

  p_active_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cap_mode) == 2'd0) |-> (!out_vblank && !out_hblank));

  p_vblank_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cap_mode) == 2'd1) |-> (out_vblank && !out_hblank));

  p_mode_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(cap_mode) != 2'd3));

  p_valid_after_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(din_en));

  p_line_mark_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_line_start |-> out_valid);

  p_field_mark_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_field_start |-> out_valid);
endmodule

bind vid656_rx vid656_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .din_en(din_en), .cap_mode(cap_mode),
  .out_valid(out_valid), .out_line_start(out_line_start),
  .out_field_start(out_field_start), .out_vblank(out_vblank),
  .out_hblank(out_hblank), .xy_fixed(xy_fixed), .xy_bad(xy_bad),
  .fvh_q(fvh_q), .sync_ok(sync_ok)
);

// File: tb/vid656_rx_tb.sv
`timescale 1ns/1ps
module vid656_rx_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          din_en;
  logic [DW-1:0] din;
  logic [1:0]    cap_mode;
  logic [DW-1:0] out_data;
  logic out_valid, out_line_start, out_field_start;
  logic out_field, out_vblank, out_hblank, xy_fixed, xy_bad;

  always #2.5 clk = ~clk;

  vid656_rx u_dut (
    .clk(clk), .rst_n(rst_n), .din_en(din_en), .din(din), .cap_mode(cap_mode),
    .out_data(out_data), .out_valid(out_valid), .out_line_start(out_line_start),
    .out_field_start(out_field_start), .out_field(out_field),
    .out_vblank(out_vblank), .out_hblank(out_hblank),
    .xy_fixed(xy_fixed), .xy_bad(xy_bad)
  );

  typedef struct {
    logic [DW-1:0] d;
    bit ls, fs, f, v, h;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   mon_on = 0;
  bit   done = 0;
  bit   m_sync, m_f, m_v, m_h, m_lp, m_fp;
  int   m_mode;

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic string mode_tag(int m);
    case (m)
      0: return "R6";
      1: return "R7";
      2: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic bit admits(int m, bit v, bit h);
    case (m)
      0: return !v && !h;
      1: return v && !h;
      2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send_word(logic [DW-1:0] w);
    din = w;
    din_en = 1'b1;
    @(posedge clk);
    #1;
    din_en = 1'b0;
  endtask

  task automatic idle();
    din_en = 1'b0;
    @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R10", "valid after idle edge", out_valid, 0);
  endtask

  task automatic send_sample(logic [DW-1:0] w);
    if (m_sync && admits(m_mode, m_v, m_h)) begin
      exp_q.push_back('{d: w, ls: m_lp, fs: m_fp, f: m_f, v: m_v, h: m_h});
      m_lp = 0;
      m_fp = 0;
    end
    send_word(w);
  endtask

  // Code: all-ones, zero, zero, status word; parity per R2
  task automatic send_code(bit f, bit v, bit h, logic [6:0] emask, int wt);
    logic [6:0] xy7;
    xy7 = {f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h} ^ emask;
    send_word('1);
    send_word('0);
    send_word('0);
    send_word({1'b1, xy7});
    check(xy_fixed == (wt == 1), "R3", "xy_fixed", xy_fixed, int'(wt == 1));
    check(xy_bad == (wt >= 2), "R4", "xy_bad", xy_bad, int'(wt >= 2));
    if (wt < 2) begin
      if (h) m_lp = 1;
      if (f != m_f) m_fp = 1;
      m_f = f; m_v = v; m_h = h;
      m_sync = 1;
    end
  endtask

  task automatic set_mode(int m);
    send_code(m_f, m_v, 1'b1, 7'd0, 0);
    cap_mode = 2'(m);
    m_mode = m;
  endtask

  always @(negedge clk) begin
    if (mon_on && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, mode_tag(m_mode), "unexpected sample", out_data, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(out_data == e.d, "R1", "sample order", out_data, e.d);
        check(out_line_start == e.ls, "R11", "line start", out_line_start, e.ls);
        check(out_field_start == e.fs, "R12", "field start", out_field_start, e.fs);
        check({out_field, out_vblank, out_hblank} == {e.f, e.v, e.h},
              "R2/R13", "flags", {out_field, out_vblank, out_hblank}, {e.f, e.v, e.h});
      end
    end
  end

  task automatic send_line(bit f, bit v, int base);
    send_code(f, v, 1'b1, 7'd0, 0);
    for (int k = 0; k < 3; k++) send_sample(DW'((base + k) % 250 + 1));
    send_code(f, v, 1'b0, 7'd0, 0);
    for (int k = 3; k < 7; k++) send_sample(DW'((base + k) % 250 + 1));
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0;
    din_en = 1'b0;
    din = '0;
    cap_mode = 2'd2;
    m_mode = 2;
    m_sync = 0; m_f = 0; m_v = 0; m_h = 0; m_lp = 0; m_fp = 0;
    repeat (4) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R5", "reset valid", out_valid, 0);
    check(out_data == '0, "R5", "reset data", out_data, 0);
    check(xy_fixed == 1'b0 && xy_bad == 1'b0, "R4", "reset pulses",
          {xy_fixed, xy_bad}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    mon_on = 1;

    // R5: no forwarding before a usable status word, even after a bad one
    for (int k = 0; k < 6; k++) send_sample(DW'(k + 40));
    send_code(1'b0, 1'b0, 1'b0, 7'b0000011, 2);
    for (int k = 0; k < 6; k++) send_sample(DW'(k + 60));
    check(exp_q.size() == 0, "R5", "queued before sync", exp_q.size(), 0);

    // R10: latency counted in enabled edges, across idle gaps
    send_code(1'b0, 1'b0, 1'b0, 7'd0, 0);
    send_sample(8'h5A);
    idle();
    send_sample(8'h11);
    check(out_valid == 1'b0, "R10", "early valid 1", out_valid, 0);
    idle();
    send_sample(8'h12);
    check(out_valid == 1'b0, "R10", "early valid 2", out_valid, 0);
    send_sample(8'h13);
    check(out_valid == 1'b1 && out_data == 8'h5A, "R10", "third edge data",
          out_data, 8'h5A);

    // R6..R9: each capture mode over two fields with mixed line types
    base = 0;
    for (int m = 0; m < 4; m++) begin
      set_mode(m);
      for (int fld = 0; fld < 2; fld++) begin
        for (int ln = 0; ln < 6; ln++) begin
          send_line(fld[0], (ln < 2 || ln == 5), base);
          base += 7;
        end
      end
    end

    // R3/R4: every flag set with no error, each single and each double error
    set_mode(2);
    for (int fvh = 0; fvh < 8; fvh++) begin
      send_code(fvh[2], fvh[1], fvh[0], 7'd0, 0);
      send_sample(DW'(fvh + 100));
      for (int a = 0; a < 7; a++) begin
        for (int b = a; b < 7; b++) begin
          logic [6:0] msk;
          msk = 7'(1 << a) | 7'(1 << b);
          send_code(fvh[2], fvh[1], fvh[0], msk, (a == b) ? 1 : 2);
          send_sample(DW'((a * 7 + b) % 200 + 20));
          send_sample(DW'((a + b) % 200 + 3));
        end
      end
    end

    // Flush the pipeline and confirm nothing is left outstanding
    send_code(m_f, m_v, 1'b1, 7'd0, 0);
    repeat (4) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R1", "samples never delivered", exp_q.size(), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule